// File: doc/BRIEF.md
# Iterative Unsigned Multiplier

This block forms the 32-bit product of two 16-bit unsigned numbers with one adder reused over sixteen clock cycles. A one-cycle pulse on `start` captures both operands and clears the product. The block then walks through the multiplier one bit per cycle, starting at its least significant bit. In each cycle that bit gates the multiplicand into a partial product. The partial product is added to the upper half of the running product, and the whole product moves one place to the right.

The 17-bit adder result is split in two. Its upper sixteen bits become the new upper half. Its lowest bit enters the top of the lower half, so the lower half fills one bit per cycle. After the sixteenth step `done` is high for one cycle. The product then stays unchanged until the next accepted start.

The controller has three states. IDLE waits and moves to RUN when `start` is high. RUN performs one step per cycle and moves to DONE after its sixteenth step. DONE raises `done` and returns to IDLE on the next cycle. A start seen in RUN or DONE is ignored.

Top module: `iter_umul`

## Requirements
- R1: While reset is held and directly after it, `done` is 0 and `product` is 0.
- R2: A start accepted in IDLE captures `op_a` and `op_b` and clears the product, so `product` reads 0 in the cycle right after the accepting edge, whatever the previous result was.
- R3: `done` goes high exactly 17 rising edges after the edge that accepted start, counting that edge as the first, and stays high for exactly one cycle.
- R4: When `done` is high, `product` equals `op_a * op_b` as 32-bit unsigned, using the values captured at start.
- R5: Outside RUN the product holds its value; after `done` it stays unchanged until the next accepted start.
- R6: A start pulse during RUN has no effect: completion timing and the result both belong to the operation already in progress.
- R7: Changes on `op_a` and `op_b` after the accepting edge do not affect the result.
- R8: After the first step, product bit 15 equals `op_a[0] & op_b[0]`. This holds because the adder's low bit enters the top of the lower half, bits 15 to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a new multiplication, honoured in IDLE only |
| op_a | input | 16 | Multiplicand |
| op_b | input | 16 | Multiplier, consumed least significant bit first |
| product | output | 32 | Running and final product, upper half in bits 31:16 |
| done | output | 1 | One-cycle pulse when the product is complete |

## Verification
The bench targets operands whose products carry all the way across the adder, such as all-ones times all-ones. It also covers a zero multiplicand and a single-bit multiplier in the top position; a dropped adder carry or a misrouted low bit shows up as a wrong result there.

It restarts straight after a nonzero result to catch a product that is not cleared. It pulses start in the middle of a run to catch a controller that restarts, which would move the `done` pulse and change the result. It also changes the operands mid-run to catch operands that are read live instead of captured.

Finally, it measures the exact edge on which `done` rises and checks that the product holds afterwards. A counter off by one, or a product still shifting after completion, fails these checks.

// File: rtl/iter_umul_pkg.sv
package iter_umul_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } umul_state_e;
endpackage

// File: rtl/umul_ctrl.sv
module umul_ctrl
    import iter_umul_pkg::*;
#(
    parameter int STEPS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic step,
    output logic done_o
);
    localparam int CNT_W = (STEPS > 1) ? $clog2(STEPS) : 1;
    localparam logic [CNT_W-1:0] LAST    = CNT_W'(STEPS - 1);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    umul_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start)         state_d = ST_RUN;
            ST_RUN:  if (cnt_q == LAST) state_d = ST_DONE;
            ST_DONE:                    state_d = ST_IDLE;
            default:                    state_d = ST_IDLE;
        endcase
    end

    // step counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt_q <= '0;
        else if (load) cnt_q <= '0;
        else if (step) cnt_q <= cnt_q + CNT_ONE;
    end

    // outputs decoded from state
    always_comb begin
        load   = 1'b0;
        step   = 1'b0;
        done_o = 1'b0;
        unique case (state_q)
            ST_IDLE: load   = start;
            ST_RUN:  step   = 1'b1;
            ST_DONE: done_o = 1'b1;
            default: ;
        endcase
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R3

    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && start && cnt_q != LAST)
        |=> (state_q == ST_RUN && cnt_q == $past(cnt_q) + CNT_ONE)); // R6

    AST_LOAD_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (state_q == ST_IDLE)); // R6
endmodule

// File: rtl/umul_ppgen.sv
module umul_ppgen #(
    parameter int W = 16
) (
    input  logic [W-1:0] mcand,
    input  logic         gate_bit,
    output logic [W-1:0] pp
);
    for (genvar i = 0; i < W; i++) begin : g_and
        assign pp[i] = mcand[i] & gate_bit;
    end
endmodule

// File: rtl/umul_dp.sv
module umul_dp #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    output logic [2*W-1:0] product_o
);
    logic [W-1:0] mcand_q, mplier_q, hi_q, lo_q;
    logic [W-1:0] pp;
    logic [W:0]   sum;

    umul_ppgen #(.W(W)) i_ppgen (
        .mcand    (mcand_q),
        .gate_bit (mplier_q[0]),
        .pp       (pp)
    );

    always_comb begin
        sum = {1'b0, hi_q} + {1'b0, pp};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mcand_q  <= '0;
            mplier_q <= '0;
            hi_q     <= '0;
            lo_q     <= '0;
        end else if (load) begin
            mcand_q  <= a_in;
            mplier_q <= b_in;
            hi_q     <= '0;
            lo_q     <= '0;
        end else if (step) begin
            mplier_q <= {1'b0, mplier_q[W-1:1]};
            hi_q     <= sum[W:1];
            lo_q     <= {sum[0], lo_q[W-1:1]};
        end
    end

    assign product_o = {hi_q, lo_q};

    AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (product_o == '0)); // R2

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> $stable(product_o)); // R5
endmodule

// File: rtl/iter_umul.sv
module iter_umul #(
    parameter int WIDTH = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [WIDTH-1:0]   op_a,
    input  logic [WIDTH-1:0]   op_b,
    output logic [2*WIDTH-1:0] product,
    output logic               done
);
    logic load, step;

    umul_ctrl #(.STEPS(WIDTH)) i_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .load   (load),
        .step   (step),
        .done_o (done)
    );

    umul_dp #(.W(WIDTH)) i_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .step      (step),
        .a_in      (op_a),
        .b_in      (op_b),
        .product_o (product)
    );

    AST_DONE_NOT_WITH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !load); // R6
endmodule

// File: tb/test_iter_umul.sv
module test_iter_umul;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] op_a = '0, op_b = '0;
    logic [31:0] product;
    logic        done;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    logic [31:0] exp_q[$];

    always #5 clk = ~clk;

    iter_umul i_iter_umul (
        .clk(clk), .rst_n(rst_n), .start(start),
        .op_a(op_a), .op_b(op_b), .product(product), .done(done)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: pops the scoreboard on each done pulse
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R4 unexpected done", product, 32'h0);
            end else begin
                logic [31:0] e;
                e = exp_q.pop_front();
                chk(product == e, "R4 product", product, e);
            end
        end
    end

    // driver
    task automatic run(input logic [15:0] a, input logic [15:0] b,
                       input bit mid_start, input bit chg_ops);
        int k;
        logic [31:0] held;
        @(negedge clk);
        op_a = a; op_b = b; start = 1'b1;
        exp_q.push_back({16'h0, a} * {16'h0, b});
        @(negedge clk);
        start = 1'b0;
        chk(product == 32'h0, "R2 cleared on start", product, 32'h0);
        if (chg_ops) begin op_a = ~a; op_b = b ^ 16'h5A5A; end // R7
        @(negedge clk);
        chk(product[15] == (a[0] & b[0]), "R8 first low bit",
            {31'h0, product[15]}, {31'h0, a[0] & b[0]});
        k = 2;
        while (!done && k < 40) begin
            @(negedge clk);
            k++;
            if (mid_start && k == 6) begin
                start = 1'b1; op_a = 16'h1111; op_b = 16'h7777; // R6
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
        chk(k == 17, "R3 done timing", 32'(k), 32'd17);
        held = product;
        @(negedge clk);
        chk(done == 1'b0, "R3 done one cycle", {31'h0, done}, 32'h0);
        chk(product == held, "R5 product held", product, held);
        @(negedge clk);
        chk(product == held, "R5 product held", product, held);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        chk(done == 1'b0, "R1 reset done", {31'h0, done}, 32'h0);
        chk(product == 32'h0, "R1 reset product", product, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(product == 32'h0 && done == 1'b0, "R1 after reset", product, 32'h0);

        run(16'd3,    16'd5,    1'b0, 1'b0);
        run(16'hFFFF, 16'hFFFF, 1'b0, 1'b0);
        run(16'h0000, 16'h1234, 1'b0, 1'b0);
        run(16'h0001, 16'hFFFF, 1'b0, 1'b0);
        run(16'hABCD, 16'h8000, 1'b0, 1'b0);
        run(16'h1234, 16'hABCD, 1'b1, 1'b0);
        run(16'hC3A5, 16'h0F0F, 1'b0, 1'b1);
        run(16'h8001, 16'h8001, 1'b1, 1'b1);

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R4 all results seen", 32'(exp_q.size()), 32'h0);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule